// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This unit forms the second ALU operand of a 32-bit load/store core together with the shifter carry-out. One source is an instruction's 12-bit operand field, which can hold a rotated 8-bit constant, a shift by an immediate amount, or a shift by a register amount. The other source is a memory offset field, which can hold a zero-extended 12-bit offset or a register offset shifted by an immediate. The register file supplies the value of the source register and the value of the amount register. The flag logic supplies the current carry.

A shift amount of zero in the immediate field does not mean "shift by zero" for every shift type. It selects pass-through, a shift by 32, or a one-bit rotate through carry, depending on the type. The unit also reports whether the operand needs one extra internal cycle, which is the case for a shift by register. All three results are registered, so they appear one clock after the inputs are sampled.

Top module: `bshop_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `operand_q`, `carry_q` and `extra_cycle_q` become 0.
- R2: Each output reflects the inputs sampled at the previous rising edge, which is a latency of exactly one clock.
- R3: With `use_imm`=1 and `mem_mode`=0, the operand is `field[7:0]` rotated right by 2*`field[11:8]`. The carry is bit 31 of the result when that rotate amount is non-zero, and `carry_in` otherwise.
- R4: With `use_imm`=1 and `mem_mode`=1, the operand is `field[11:0]` zero-extended and the carry is `carry_in`. `shift_by_reg` has no effect and `extra_cycle_q` is 0.
- R5: With `use_imm`=0, the shift type is taken from `field[6:5]`: 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right. The value shifted is `rm_val`. For a shift by immediate the amount is `field[11:7]`.
- R6: A logical left shift by an immediate amount of 0 returns `rm_val` unchanged, and the carry is `carry_in`.
- R7: A rotate right by an immediate amount of 0 is a one-bit rotate through carry. The operand is {`carry_in`, `rm_val[31:1]`} and the carry is `rm_val[0]`.
- R8: A logical right or arithmetic right shift by an immediate amount of 0 acts as a shift by 32, in both modes.
- R9: With `use_imm`=0, `shift_by_reg`=1 and `mem_mode`=0, the amount is `rs_val[7:0]` and `extra_cycle_q` is 1. In every other case `extra_cycle_q` is 0. With `mem_mode`=1, `shift_by_reg` is ignored.
- R10: A shift by register with an amount of 0 leaves both the operand (`rm_val`) and the carry (`carry_in`) unchanged.
- R11: A logical shift by exactly 32 gives 0, with the carry equal to `rm_val[0]` for a left shift or `rm_val[31]` for a right shift. A logical shift by more than 32 gives 0 with the carry cleared.
- R12: An arithmetic right shift by 32 or more fills every bit with `rm_val[31]`, and the carry equals `rm_val[31]`.
- R13: A rotate right by a non-zero multiple of 32 returns `rm_val` with carry `rm_val[31]`. Any other non-zero rotate amount rotates by the amount modulo 32, and the carry is bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field | input | 12 | Operand or offset field of the instruction |
| rm_val | input | 32 | Value of the shifted source register |
| rs_val | input | 32 | Value of the shift-amount register |
| use_imm | input | 1 | 1: immediate form (rotated constant or 12-bit offset) |
| shift_by_reg | input | 1 | 1: shift amount comes from `rs_val` |
| mem_mode | input | 1 | 0: data-processing operand, 1: word/byte memory offset |
| carry_in | input | 1 | Current carry flag |
| operand_q | output | 32 | Registered operand |
| carry_q | output | 1 | Registered shifter carry-out |
| extra_cycle_q | output | 1 | Registered extra-internal-cycle indication |

## Verification
The assertions check on every cycle the behaviours that depend on a single input condition: the extra-cycle flag, pass-through for a register amount of zero and for a logical left shift by zero, the zero-extended memory offset, and saturation of large arithmetic shifts. The general shift results are only shown by the bench scenarios. These are the carry bit taken from the right position for each type and amount, the boundary at exactly 32 compared with 33 and larger, rotate amounts above 32, the rotate through carry, and the rotated constant with and without rotation. The bench compares each of them against a bit-serial reference on every clock.

// File: rtl/bshop_pkg.sv
package bshop_pkg;

  // Shift type code taken from field bits [6:5]
  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shift_kind_e;

  localparam int FIELD_W    = 12;
  localparam int IMM8_W     = 8;
  localparam int ROT_LO     = 8;
  localparam int ROT_W      = 4;
  localparam int SAMT_LO    = 7;
  localparam int SAMT_W     = 5;
  localparam int KIND_LO    = 5;
  localparam int RS_AMT_W   = 8;

endpackage

// File: rtl/bshop_decode.sv
module bshop_decode
  import bshop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = RS_AMT_W
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic               use_imm,
  input  logic               shift_by_reg,
  input  logic               mem_mode,
  output logic [DATA_W-1:0]  src,
  output shift_kind_e        kind,
  output logic [AMT_W-1:0]   amt,
  output logic               rrx,
  output logic               extra
);

  logic [SAMT_W-1:0] imm_amt;
  shift_kind_e       fld_kind;

  always_comb begin
    imm_amt  = field[SAMT_LO +: SAMT_W];
    fld_kind = shift_kind_e'(field[KIND_LO +: 2]);
    src      = rm_val;
    kind     = fld_kind;
    amt      = '0;
    rrx      = 1'b0;
    extra    = 1'b0;
    if (use_imm && mem_mode) begin
      // plain 12-bit offset, no shift
      src  = DATA_W'(field);
      kind = SHK_LSL;
    end else if (use_imm) begin
      // rotated constant: rotate by twice the 4-bit field
      src  = DATA_W'(field[IMM8_W-1:0]);
      kind = SHK_ROR;
      amt  = AMT_W'({field[ROT_LO +: ROT_W], 1'b0});
    end else if (shift_by_reg && !mem_mode) begin
      amt   = rs_val[AMT_W-1:0];
      extra = 1'b1;
    end else begin
      amt = AMT_W'(imm_amt);
      if (imm_amt == '0) begin
        unique case (fld_kind)
          SHK_LSL: amt = '0;
          SHK_LSR,
          SHK_ASR: amt = AMT_W'(DATA_W);
          SHK_ROR: rrx = 1'b1;
          default: amt = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/bshop_core.sv
module bshop_core
  import bshop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = RS_AMT_W
) (
  input  logic [DATA_W-1:0] src,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              rrx,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W:0] FULL = (IDX_W+1)'(DATA_W);

  logic [DATA_W:0]   lsl_w;
  logic [DATA_W:0]   lsr_w;
  logic [DATA_W:0]   asr_w;
  logic [AMT_W-1:0]  asr_amt;
  logic [IDX_W-1:0]  rot_k;
  logic [DATA_W-1:0] rot_v;

  always_comb begin
    // extra bit beside the data catches the last bit shifted out
    lsl_w   = {1'b0, src} << amt;
    lsr_w   = {src, 1'b0} >> amt;
    asr_amt = (amt > AMT_W'(DATA_W)) ? AMT_W'(DATA_W) : amt;
    asr_w   = $unsigned($signed({src, 1'b0}) >>> asr_amt);
    rot_k   = amt[IDX_W-1:0];
    rot_v   = (src >> rot_k) | (src << (FULL - {1'b0, rot_k}));
  end

  always_comb begin
    res  = src;
    cout = cin;
    if (rrx) begin
      res  = {cin, src[DATA_W-1:1]};
      cout = src[0];
    end else if (amt != '0) begin
      unique case (kind)
        SHK_LSL: {cout, res} = lsl_w;
        SHK_LSR: {res, cout} = lsr_w;
        SHK_ASR: {res, cout} = asr_w;
        SHK_ROR: begin
          res  = rot_v;
          cout = rot_v[DATA_W-1];
        end
        default: begin
          res  = src;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/bshop_unit.sv
module bshop_unit
  import bshop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = RS_AMT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] field,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic               use_imm,
  input  logic               shift_by_reg,
  input  logic               mem_mode,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  operand_q,
  output logic               carry_q,
  output logic               extra_cycle_q
);

  logic [DATA_W-1:0] d_src;
  shift_kind_e       d_kind;
  logic [AMT_W-1:0]  d_amt;
  logic              d_rrx;
  logic              d_extra;
  logic [DATA_W-1:0] c_res;
  logic              c_cout;

  bshop_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
    .field        (field),
    .rm_val       (rm_val),
    .rs_val       (rs_val),
    .use_imm      (use_imm),
    .shift_by_reg (shift_by_reg),
    .mem_mode     (mem_mode),
    .src          (d_src),
    .kind         (d_kind),
    .amt          (d_amt),
    .rrx          (d_rrx),
    .extra        (d_extra)
  );

  bshop_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .src  (d_src),
    .kind (d_kind),
    .amt  (d_amt),
    .rrx  (d_rrx),
    .cin  (carry_in),
    .res  (c_res),
    .cout (c_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand_q     <= '0;
      carry_q       <= 1'b0;
      extra_cycle_q <= 1'b0;
    end else begin
      operand_q     <= c_res;
      carry_q       <= c_cout;
      extra_cycle_q <= d_extra;
    end
  end

  logic reg_form;
  assign reg_form = !use_imm && shift_by_reg && !mem_mode;

  // R9: extra cycle only for a data-processing shift by register
  assert_extra_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (extra_cycle_q == $past(reg_form)));

  // R10: register amount of zero passes value and carry through
  assert_reg_zero_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_form && rs_val[AMT_W-1:0] == '0) |=>
      (operand_q == $past(rm_val) && carry_q == $past(carry_in)));

  // R6: logical left by immediate zero is a pass-through
  assert_lsl0_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (!use_imm && !reg_form && field[KIND_LO +: 2] == 2'b00 &&
     field[SAMT_LO +: SAMT_W] == '0) |=>
      (operand_q == $past(rm_val) && carry_q == $past(carry_in)));

  // R4: memory immediate offset is zero-extended, carry untouched
  assert_mem_imm_R4: assert property (@(posedge clk) disable iff (rst)
    (use_imm && mem_mode) |=>
      (operand_q == DATA_W'($past(field)) && carry_q == $past(carry_in) &&
       !extra_cycle_q));

  // R12: arithmetic right by 32 or more saturates to the sign
  assert_asr_sat_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_form && field[KIND_LO +: 2] == 2'b10 &&
     rs_val[AMT_W-1:0] >= AMT_W'(DATA_W)) |=>
      (operand_q == {DATA_W{$past(rm_val[DATA_W-1])}} &&
       carry_q == $past(rm_val[DATA_W-1])));

endmodule

// File: tb/test_bshop_unit.sv
module test_bshop_unit;

  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] field;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        use_imm;
  logic        shift_by_reg;
  logic        mem_mode;
  logic        carry_in;
  logic [31:0] operand_q;
  logic        carry_q;
  logic        extra_cycle_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [33:0] exp_v;
  bit          have_exp = 0;
  string       exp_tag;

  always #(HALF) clk = ~clk;

  bshop_unit i_bshop_unit (
    .clk(clk), .rst(rst), .field(field), .rm_val(rm_val), .rs_val(rs_val),
    .use_imm(use_imm), .shift_by_reg(shift_by_reg), .mem_mode(mem_mode),
    .carry_in(carry_in), .operand_q(operand_q), .carry_q(carry_q),
    .extra_cycle_q(extra_cycle_q)
  );

  // Bit-serial reference: returns {extra, carry, value}
  function automatic logic [33:0] model(logic [11:0] f, logic [31:0] rm,
      logic [31:0] rs, logic ui, logic sbr, logic mm, logic ci);
    logic [31:0] v;
    logic        c;
    int          n;
    int          kd;
    logic        ex;
    c  = ci;
    ex = !ui && sbr && !mm;
    if (ui && mm) return {1'b0, ci, 20'd0, f};
    if (ui) begin
      v = {24'd0, f[7:0]}; n = 2 * int'(f[11:8]); kd = 3;
    end else begin
      v = rm; kd = int'(f[6:5]);
      if (ex) n = int'(rs[7:0]);
      else begin
        n = int'(f[11:7]);
        if (n == 0) begin
          if (kd == 1 || kd == 2) n = 32;
          else if (kd == 3) return {1'b0, rm[0], ci, rm[31:1]};
        end
      end
    end
    for (int k = 0; k < n; k++) begin
      case (kd)
        0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {ex, c, v};
  endfunction

  task automatic compare_now();
    total++;
    if ({extra_cycle_q, carry_q, operand_q} !== exp_v) begin
      bad++;
      $display("FAIL %s: got extra=%0b carry=%0b op=%h, exp extra=%0b carry=%0b op=%h",
               exp_tag, extra_cycle_q, carry_q, operand_q,
               exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic apply(logic [11:0] f, logic [31:0] rm, logic [31:0] rs,
      logic ui, logic sbr, logic mm, logic ci, string tag);
    @(negedge clk);
    if (have_exp) compare_now();
    field = f; rm_val = rm; rs_val = rs; use_imm = ui;
    shift_by_reg = sbr; mem_mode = mm; carry_in = ci;
    exp_v = model(f, rm, rs, ui, sbr, mm, ci);
    exp_tag = tag;
    have_exp = 1;
  endtask

  function automatic logic [11:0] fi(int amt, int kd);
    return {5'(amt), 2'(kd), 1'b0, 4'd2};
  endfunction
  function automatic logic [11:0] fr(int kd);
    return {4'd3, 1'b0, 2'(kd), 1'b1, 4'd2};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, got hang, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; field = '0; rm_val = 32'hFFFF_FFFF; rs_val = '0;
    use_imm = 1'b0; shift_by_reg = 1'b1; mem_mode = 1'b0; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if ({extra_cycle_q, carry_q, operand_q} !== 34'd0) begin
      bad++;
      $display("FAIL R1: got %h, exp 0", {extra_cycle_q, carry_q, operand_q});
    end
    rst = 1'b0;

    // R3 rotated constant
    apply(12'h4FF, 32'h0, 32'h0, 1, 0, 0, 0, "R3 rot by 8");
    apply(12'h0AB, 32'h0, 32'h0, 1, 0, 0, 1, "R3 no rotate keeps carry");
    apply(12'h1F1, 32'h0, 32'h0, 1, 0, 0, 0, "R3 rot by 2 carry");
    // R4 memory offset
    apply(12'hABC, 32'h1234, 32'h1, 1, 1, 1, 1, "R4 mem imm, shift_by_reg ignored");
    apply(fr(0), 32'h8000_0001, 32'h4, 0, 1, 1, 0, "R4 R9 mem ignores register amount");
    // R5 basic shifts
    apply(fi(4, 0), 32'h8765_4321, 0, 0, 0, 0, 0, "R5 lsl 4");
    apply(fi(3, 1), 32'h8765_4325, 0, 0, 0, 0, 0, "R5 lsr 3");
    apply(fi(7, 2), 32'h8765_4321, 0, 0, 0, 0, 0, "R5 asr 7");
    apply(fi(9, 3), 32'h8765_4321, 0, 0, 0, 1, 0, "R5 ror 9 mem mode");
    // R6 R7 R8 zero-immediate reinterpretation
    apply(fi(0, 0), 32'hDEAD_BEEF, 0, 0, 0, 0, 1, "R6 lsl 0");
    apply(fi(0, 3), 32'hDEAD_BEEF, 0, 0, 0, 0, 1, "R7 rrx carry in");
    apply(fi(0, 3), 32'h0000_0002, 0, 0, 0, 0, 0, "R7 rrx carry out 0");
    apply(fi(0, 1), 32'h8000_0000, 0, 0, 0, 0, 0, "R8 lsr 0 as 32");
    apply(fi(0, 2), 32'h8000_0000, 0, 0, 0, 1, 0, "R8 asr 0 as 32 mem");
    apply(fi(0, 2), 32'h7FFF_FFFF, 0, 0, 0, 0, 1, "R8 asr 0 positive");
    // R9 R10 register shifts
    apply(fr(0), 32'h0000_00F0, 32'hFFFF_FF04, 0, 1, 0, 0, "R9 lsl by low byte 4");
    apply(fr(1), 32'hCAFE_F00D, 32'h0000_1100, 0, 1, 0, 1, "R10 reg amount 0");
    apply(fr(3), 32'hCAFE_F00D, 32'h0000_0000, 0, 1, 0, 0, "R10 ror reg 0");
    // R11 logical boundaries
    apply(fr(0), 32'h0000_0001, 32'd32, 0, 1, 0, 0, "R11 lsl 32");
    apply(fr(0), 32'hFFFF_FFFF, 32'd33, 0, 1, 0, 1, "R11 lsl 33");
    apply(fr(1), 32'h8000_0000, 32'd32, 0, 1, 0, 0, "R11 lsr 32");
    apply(fr(1), 32'hFFFF_FFFF, 32'd200, 0, 1, 0, 1, "R11 lsr 200");
    apply(fr(0), 32'h4000_0001, 32'd31, 0, 1, 0, 0, "R11 lsl 31");
    // R12 arithmetic saturation
    apply(fr(2), 32'h8000_0000, 32'd40, 0, 1, 0, 0, "R12 asr 40 neg");
    apply(fr(2), 32'h7000_0000, 32'd255, 0, 1, 0, 1, "R12 asr 255 pos");
    apply(fr(2), 32'h8000_0000, 32'd32, 0, 1, 0, 0, "R12 asr 32");
    // R13 rotates
    apply(fr(3), 32'h8000_0001, 32'd32, 0, 1, 0, 0, "R13 ror 32");
    apply(fr(3), 32'h0000_0001, 32'd64, 0, 1, 0, 1, "R13 ror 64");
    apply(fr(3), 32'h1234_5678, 32'd36, 0, 1, 0, 0, "R13 ror 36");
    apply(fr(3), 32'h0000_0010, 32'd5, 0, 1, 0, 0, "R13 ror 5");
    // R2 back-to-back random traffic, checked every clock
    for (int i = 0; i < 400; i++) begin
      apply(12'($urandom), $urandom, 32'($urandom_range(0, 70)) | ($urandom & 32'hFFFF_FF00),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2 random stream");
    end
    @(negedge clk);
    compare_now();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule